// File: doc/BRIEF.md
# Queued DMA Command Engine with Interrupt Status

This block accepts DMA commands from a small word-addressed register port, holds them in a command queue, and executes them one at a time over a single-word memory port. Software fills in a source address, a destination address and two word counts. The final write, to the destination word count, captures all four values as one command. Addresses are forced to 32-bit alignment when the command is captured. Counts are in 32-bit words.

The engine takes the command at the head of the queue and moves it in bursts. Each burst reads up to 256 words into an internal buffer. When the loopback mode bit is set, the burst then writes the same words to the destination. Once both remaining counts of a command are zero, the command leaves the queue and two completion flags are raised. The flags live in a write-one-to-clear status register. A mask register gates them into a single level-sensitive interrupt.

The memory port uses a valid/ready handshake. The engine raises `mem_valid` and holds `mem_write`, `mem_addr` and `mem_wdata` steady until the memory raises `mem_ready`. One word moves in each cycle where both are high. For a read, the memory presents `mem_rdata` in that same cycle. The memory may hold `mem_ready` low for as long as it needs, and the engine simply waits.

Top module: `dmaq_engine`

## Requirements
- R1: A write to register index 3 (destination count) pushes one command built from the current source address, destination address and source count plus the written value. Writes to any other index never start memory traffic.
- R2: A captured command has the low two bits of both addresses cleared. Beat k of a burst targets the address plus 4·k.
- R3: The source and destination count registers (indices 2 and 3) keep only bits 26:0 of a write and read back zero above them.
- R4: The queue holds 10 commands, including the one in progress. Register index 6 reports full in bit 31 and empty in bit 30, and reads 0x4000_0000 after reset.
- R5: A push while the queue is full is dropped and sets status bit 14.
- R6: A burst moves min(256, remaining source words) words. In loopback the remaining destination words also bound it. All the reads of a burst come before its writes.
- R7: With mode register (index 7) bit 4 set, every word read is written to the destination in order. With it clear, no write is issued.
- R8: A command retires when both remaining counts are zero. Retiring sets status bits 13 and 12 and removes the command. A command with both counts zero retires with no memory access.
- R9: `irq` is high exactly when some bit is set in both the status register (index 4) and the inverted mask register (index 5). The mask resets to all ones.
- R10: Writing ones to the status register clears those bits. Status bits 26:24 and 19 always read zero, and the same mask bits always read one. Status resets to 0x8802_0000.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold their values. One word moves per accepted beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat is a write (1) or a read (0) |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |

## Verification
The hardest state to reach from the ports is a full queue, because the engine starts draining the head command as soon as it arrives. The bench holds `mem_ready` low so that the first command stalls on its first beat. It then pushes ten commands to reach full, and an eleventh to cause an overflow. After that it releases the memory and confirms that only the ten accepted commands generated traffic. Burst splitting is exercised by a sweep of loopback counts that straddle the 256-word limit. The bench rebuilds the exact read/write beat sequence from the count arithmetic and compares it beat by beat.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 27;

  typedef struct packed {
    logic [ADDR_W-1:0] src_a;
    logic [ADDR_W-1:0] dst_a;
    logic [LEN_W-1:0]  src_n;
    logic [LEN_W-1:0]  dst_n;
  } dmaq_cmd_t;

  // register word indices
  localparam logic [2:0] RI_SRC_A = 3'd0;
  localparam logic [2:0] RI_DST_A = 3'd1;
  localparam logic [2:0] RI_SRC_N = 3'd2;
  localparam logic [2:0] RI_DST_N = 3'd3;
  localparam logic [2:0] RI_ISTAT = 3'd4;
  localparam logic [2:0] RI_IMASK = 3'd5;
  localparam logic [2:0] RI_QSTAT = 3'd6;
  localparam logic [2:0] RI_MODE  = 3'd7;

  localparam logic [31:0] ISTAT_RSVD  = 32'h0708_0000;
  localparam logic [31:0] ISTAT_RESET = 32'h8802_0000;
  localparam int BIT_PDONE = 12;
  localparam int BIT_DONE  = 13;
  localparam int BIT_OVF   = 14;
  localparam int QS_FULL   = 31;
  localparam int QS_EMPTY  = 30;
  localparam int MODE_LB   = 4;
endpackage

// File: rtl/dmaq_cmd_fifo.sv
module dmaq_cmd_fifo
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  logic      pop,
  input  dmaq_cmd_t din,
  output dmaq_cmd_t dout,
  output logic      full,
  output logic      empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  dmaq_cmd_t        slots [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slots[rp];

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/dmaq_mover.sv
module dmaq_mover
  import dmaq_pkg::*;
#(
  parameter int BURST_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loopback,
  input  logic              q_empty,
  input  dmaq_cmd_t         head,
  output logic              retire,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IW = $clog2(BURST_WORDS);
  localparam int BW = $clog2(BURST_WORDS + 1);

  typedef enum logic [2:0] {MV_IDLE, MV_CHECK, MV_READ, MV_WRITE, MV_UPDATE} mv_state_e;

  mv_state_e         state;
  logic [ADDR_W-1:0] w_src, w_dst;
  logic [LEN_W-1:0]  w_sn, w_dn, lim;
  logic [BW-1:0]     burst;
  logic [IW-1:0]     cnt;
  logic              lb_q, fire, last, both_zero;
  logic [DATA_W-1:0] stage [BURST_WORDS];

  always_comb begin
    lim = w_sn;
    if (loopback && (w_dn < lim)) lim = w_dn;
    if (lim > LEN_W'(BURST_WORDS)) lim = LEN_W'(BURST_WORDS);
  end

  assign both_zero = (w_sn == '0) && (w_dn == '0);
  assign retire    = (state == MV_CHECK) && both_zero;
  assign mem_valid = (state == MV_READ) || (state == MV_WRITE);
  assign mem_write = (state == MV_WRITE);
  assign fire      = mem_valid && mem_ready;
  assign last      = (BW'(cnt) == burst - BW'(1));
  assign mem_addr  = (state == MV_WRITE) ? w_dst + (ADDR_W'(cnt) << 2)
                                         : w_src + (ADDR_W'(cnt) << 2);
  assign mem_wdata = stage[cnt];

  always_ff @(posedge clk) begin
    if ((state == MV_READ) && fire) stage[cnt] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MV_IDLE;
      w_src <= '0;
      w_dst <= '0;
      w_sn  <= '0;
      w_dn  <= '0;
      burst <= '0;
      cnt   <= '0;
      lb_q  <= 1'b0;
    end else begin
      case (state)
        MV_IDLE: if (!q_empty) begin
          w_src <= head.src_a;
          w_dst <= head.dst_a;
          w_sn  <= head.src_n;
          w_dn  <= head.dst_n;
          state <= MV_CHECK;
        end
        MV_CHECK: begin
          lb_q <= loopback;
          if (both_zero) begin
            state <= MV_IDLE;
          end else if (lim != '0) begin
            burst <= BW'(lim);
            cnt   <= '0;
            state <= MV_READ;
          end
        end
        MV_READ: if (fire) begin
          cnt <= cnt + IW'(1);
          if (last) begin
            cnt   <= '0;
            state <= lb_q ? MV_WRITE : MV_UPDATE;
          end
        end
        MV_WRITE: if (fire) begin
          cnt <= cnt + IW'(1);
          if (last) begin
            cnt   <= '0;
            state <= MV_UPDATE;
          end
        end
        MV_UPDATE: begin
          w_src <= w_src + (ADDR_W'(burst) << 2);
          w_sn  <= w_sn - LEN_W'(burst);
          if (lb_q) begin
            w_dst <= w_dst + (ADDR_W'(burst) << 2);
            w_dn  <= w_dn - LEN_W'(burst);
          end
          state <= MV_CHECK;
        end
        default: state <= MV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq
  import dmaq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stat,
  input  logic        wr_mask,
  input  logic [31:0] wdata,
  input  logic        set_done,
  input  logic        set_ovf,
  output logic [31:0] stat,
  output logic [31:0] mask,
  output logic        irq
);
  logic [31:0] stat_n;

  always_comb begin
    stat_n = stat;
    if (wr_stat) stat_n = stat_n & ~wdata;
    if (set_done) begin
      stat_n[BIT_DONE]  = 1'b1;
      stat_n[BIT_PDONE] = 1'b1;
    end
    if (set_ovf) stat_n[BIT_OVF] = 1'b1;
    stat_n = stat_n & ~ISTAT_RSVD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= ISTAT_RESET;
      mask <= '1;
    end else begin
      stat <= stat_n;
      if (wr_mask) mask <= wdata | ISTAT_RSVD;
    end
  end

  assign irq = |(stat & ~mask);
endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
  import dmaq_pkg::*;
#(
  parameter int QDEPTH      = 10,
  parameter int BURST_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  logic [ADDR_W-1:0] r_src_a, r_dst_a;
  logic [LEN_W-1:0]  r_src_n, r_dst_n;
  logic              r_loop;
  logic              q_push, q_full, q_empty, mv_retire;
  dmaq_cmd_t         new_cmd, head_cmd;
  logic [31:0]       stat, mask;

  assign q_push = reg_wr && (reg_addr == RI_DST_N);

  always_comb begin
    new_cmd.src_a = r_src_a & ~ADDR_W'(3);
    new_cmd.dst_a = r_dst_a & ~ADDR_W'(3);
    new_cmd.src_n = r_src_n;
    new_cmd.dst_n = reg_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_src_a <= '0;
      r_dst_a <= '0;
      r_src_n <= '0;
      r_dst_n <= '0;
      r_loop  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RI_SRC_A: r_src_a <= reg_wdata;
        RI_DST_A: r_dst_a <= reg_wdata;
        RI_SRC_N: r_src_n <= reg_wdata[LEN_W-1:0];
        RI_DST_N: r_dst_n <= reg_wdata[LEN_W-1:0];
        RI_MODE:  r_loop  <= reg_wdata[MODE_LB];
        default: ;
      endcase
    end
  end

  dmaq_cmd_fifo #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .pop(mv_retire),
    .din(new_cmd), .dout(head_cmd), .full(q_full), .empty(q_empty)
  );

  dmaq_mover #(.BURST_WORDS(BURST_WORDS)) u_mover (
    .clk(clk), .rst_n(rst_n), .loopback(r_loop), .q_empty(q_empty),
    .head(head_cmd), .retire(mv_retire),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  dmaq_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_stat(reg_wr && (reg_addr == RI_ISTAT)),
    .wr_mask(reg_wr && (reg_addr == RI_IMASK)),
    .wdata(reg_wdata), .set_done(mv_retire), .set_ovf(q_push && q_full),
    .stat(stat), .mask(mask), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_SRC_A: reg_rdata = r_src_a;
      RI_DST_A: reg_rdata = r_dst_a;
      RI_SRC_N: reg_rdata = 32'(r_src_n);
      RI_DST_N: reg_rdata = 32'(r_dst_n);
      RI_ISTAT: reg_rdata = stat;
      RI_IMASK: reg_rdata = mask;
      RI_QSTAT: begin
        reg_rdata[QS_FULL]  = q_full;
        reg_rdata[QS_EMPTY] = q_empty;
      end
      RI_MODE:  reg_rdata[MODE_LB] = r_loop;
      default: ;
    endcase
  end
endmodule

// File: rtl/dmaq_checker.sv
module dmaq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        q_push,
  input logic        q_full,
  input logic        q_empty,
  input logic        mv_retire,
  input logic [31:0] stat
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write)
      && $stable(mem_addr) && $stable(mem_wdata));

  // R9
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd5 && reg_wdata == 32'hFFFF_FFFF |=> !irq);

  // R1
  push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_push && !q_full |=> !q_empty);

  // R5
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_push && q_full |=> stat[14]);

  // R8
  retire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_retire |=> stat[13] && stat[12]);

  // R4
  queue_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));
endmodule

bind dmaq_engine dmaq_checker u_dmaq_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .q_push(q_push), .q_full(q_full),
  .q_empty(q_empty), .mv_retire(mv_retire), .stat(stat)
);

// File: tb/test_dmaq_engine.sv
module test_dmaq_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic stall = 1'b0;

  logic [31:0] bmem  [1024];
  logic        txn_w [2048];
  logic [31:0] txn_a [2048];
  int          txn_n = 0;

  always #10 clk = ~clk;

  dmaq_engine i_dmaq_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = bmem[mem_addr[11:2]];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_valid && mem_ready) begin
      if (txn_n < 2048) begin
        txn_w[txn_n] = mem_write;
        txn_a[txn_n] = mem_addr;
      end
      txn_n = txn_n + 1;
      if (mem_write) bmem[mem_addr[11:2]] = mem_wdata;
    end
  end

  always @(negedge clk) mem_ready <= !stall && (cyc % 3 != 1);

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0100_0193) ^ 32'hA5A5_0000;
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) bmem[i] = pat(i);
    txn_n = 0;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] q;
    q = '0;
    while (q[30] == 1'b0) rd(3'd6, q);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R1) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int lens [10] = '{0, 1, 2, 3, 5, 8, 255, 256, 257, 300};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(3'd4, v); check(v == 32'h8802_0000, "R10 status reset", v, 32'h8802_0000);
    rd(3'd5, v); check(v == 32'hFFFF_FFFF, "R9 mask reset", v, 32'hFFFF_FFFF);
    rd(3'd6, v); check(v == 32'h4000_0000, "R4 queue reset", v, 32'h4000_0000);
    check(irq == 1'b0, "R9 irq after reset", 32'(irq), 0);
    check(mem_valid == 1'b0, "R11 idle port", 32'(mem_valid), 0);

    // write-one-to-clear, reserved bits
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); check(v == 0, "R10 w1c clears", v, 0);
    wr(3'd5, 32'h0);
    rd(3'd5, v); check(v == 32'h0708_0000, "R10 reserved mask bits", v, 32'h0708_0000);
    check(irq == 1'b0, "R9 no status no irq", 32'(irq), 0);

    // count width
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check(v == 32'h07FF_FFFF, "R3 count truncation", v, 32'h07FF_FFFF);

    // non-trigger writes
    init_mem();
    wr(3'd0, 32'h40); wr(3'd1, 32'h800); wr(3'd2, 32'd5); wr(3'd7, 32'h10);
    repeat (30) @(negedge clk);
    check(txn_n == 0, "R1 no start without push", 32'(txn_n), 0);
    rd(3'd6, v); check(v[30] == 1'b1, "R1 queue still empty", v, 32'h4000_0000);

    // non-loopback
    init_mem();
    wr(3'd7, 32'h0); wr(3'd0, 32'h103); wr(3'd1, 32'h807); wr(3'd2, 32'd5);
    wr(3'd3, 32'd0);
    wait_idle();
    check(txn_n == 5, "R7 read-only beat count", 32'(txn_n), 5);
    begin
      int bad = 0;
      for (int k = 0; k < 5; k++)
        if (txn_w[k] || txn_a[k] != 32'h100 + 32'(4 * k)) bad++;
      check(bad == 0, "R2 aligned read addresses", 32'(bad), 0);
    end
    rd(3'd4, v); check(v == 32'h3000, "R8 done flags", v, 32'h3000);
    check(irq == 1'b1, "R9 irq unmasked", 32'(irq), 1);

    // masking and per-bit clear
    wr(3'd5, 32'h3000);
    check(irq == 1'b0, "R9 masked", 32'(irq), 0);
    wr(3'd5, 32'h0);
    wr(3'd4, 32'h2000);
    rd(3'd4, v); check(v == 32'h1000, "R10 single bit clear", v, 32'h1000);
    check(irq == 1'b1, "R9 remaining bit", 32'(irq), 1);
    wr(3'd4, 32'h1000);
    check(irq == 1'b0, "R9 all cleared", 32'(irq), 0);

    // loopback sweep
    foreach (lens[li]) begin
      int n = lens[li];
      int bad = 0;
      int p = 0;
      int rem = n;
      int moved = 0;
      init_mem();
      wr(3'd4, 32'hFFFF_FFFF);
      wr(3'd7, 32'h10);
      wr(3'd0, 32'(64 + (n % 4)));
      wr(3'd1, 32'h803);
      wr(3'd2, 32'(n));
      wr(3'd3, 32'(n));
      wait_idle();
      while (rem > 0) begin
        int b = (rem > 256) ? 256 : rem;
        for (int k = 0; k < b; k++)
          if (txn_w[p + k] || txn_a[p + k] != 32'(64 + 4 * (moved + k))) bad++;
        for (int k = 0; k < b; k++)
          if (!txn_w[p + b + k] || txn_a[p + b + k] != 32'(32'h800 + 4 * (moved + k))) bad++;
        p += 2 * b; rem -= b; moved += b;
      end
      if (txn_n != 2 * n) bad++;
      check(bad == 0, "R6 burst beat sequence", 32'(bad), 0);
      bad = 0;
      for (int k = 0; k < n; k++) if (bmem[512 + k] != pat(16 + k)) bad++;
      check(bad == 0, "R7 loopback copy", 32'(bad), 0);
      check(bmem[512 + n] == pat(512 + n), "R7 no write past end", bmem[512 + n], pat(512 + n));
      rd(3'd4, v); check(v[13:12] == 2'b11, "R8 retire flags", v, 32'h3000);
      if (n == 0) check(txn_n == 0, "R8 empty command no access", 32'(txn_n), 0);
    end

    // full queue and overflow
    init_mem();
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0);
    stall = 1'b1;
    for (int i = 0; i < 10; i++) begin
      wr(3'd0, 32'(i * 64));
      wr(3'd2, 32'd2);
      wr(3'd3, 32'd0);
    end
    rd(3'd6, v); check(v == 32'h8000_0000, "R4 queue full", v, 32'h8000_0000);
    rd(3'd4, v); check(v[14] == 1'b0, "R5 no overflow yet", v, 0);
    wr(3'd0, 32'h300);
    wr(3'd3, 32'd0);
    rd(3'd4, v); check(v[14] == 1'b1, "R5 overflow flag", v, 32'h4000);
    stall = 1'b0;
    wait_idle();
    check(txn_n == 20, "R5 dropped command no traffic", 32'(txn_n), 20);
    rd(3'd4, v); check((v & 32'h7000) == 32'h7000, "R8 flags after drain", v, 32'h7000);

    finish_run();
  end
endmodule